// File: doc/BRIEF.md
# Gen2 Stalled-Lock Recovery Monitor

This block sits beside a PCI Express root-port controller and watches two 32-bit training debug words. Sometimes a speed change to Gen2 stalls. The training state machine then stays in Recovery.RcvrLock while the PHY receiver never reports valid data. The monitor looks for this case and clears it without resetting the link. It briefly forces the PHY receiver data-enable and PLL-enable overrides, then releases them. Both steps are read-modify-write cycles on a 16-bit PHY register space, reached through a simple request/acknowledge master port. The handshake logic on the far side of that port is not part of this block.

The monitor also reports whether the link has left training. If the stall condition holds without a break for a programmable dwell time, the monitor makes one confirmation read of the PHY receive status. It only intervenes when that read shows the receiver is not valid. The override is held for a programmable time before it is released. Each completed intervention raises a one-cycle event and advances a counter. An access error ends the sequence with a one-cycle failure pulse. The sequence always tries to put the override bits back to clear.

Top module: `g2_stall_rescue`

## Requirements
- R1: `link_up` equals the inverse of bit 4 of `lt_dbg1` as sampled on the previous clock edge.
- R2: While bit 4 of `lt_dbg1` is 1, no PHY access is requested, even when the state code is 0x0D.
- R3: The stall condition is: bits [5:0] of `lt_dbg0` equal 0x0D and bit 4 of `lt_dbg1` is 0. Count the first edge that sees the condition as edge 1. The confirmation read (`phy_we`=0) of PHY address 0x100D is requested on edge DWELL_CYC+1, but only if the condition held on every edge in between. A one-cycle break restarts the count.
- R4: If bit 0 of the confirmation read data is 1, no further access follows, and neither `rec_event` nor `rec_fail` pulses.
- R5: If that bit is 0, PHY address 0x1005 is read. The value read is then written back to 0x1005 with bits 5 and 3 set and every other bit unchanged.
- R6: The clearing read of 0x1005 is requested HOLD_CYC+1 edges after the edge that accepts the acknowledge of the setting write. The value it returns is written back with bits 5 and 3 cleared and every other bit unchanged.
- R7: When the clearing write is acknowledged without error, `rec_event` pulses for one cycle and `rec_count` increases by one in that same cycle.
- R8: `rec_busy` is 1 from the first request until the final acknowledge of a sequence. No new confirmation read starts while it is 1, and `phy_req` is never 1 while it is 0.
- R9: An error on the confirmation read or on the first read of 0x1005 ends the sequence with no write. `rec_fail` pulses and `rec_count` does not change.
- R10: An error on the setting write or on the clearing read leads to one write to 0x1005. That write carries the value from the first read of 0x1005 with bits 5 and 3 cleared. `rec_fail` then pulses and `rec_count` does not change.
- R11: After `phy_req` rises, it stays 1 until `phy_ack`. While it waits, `phy_addr`, `phy_we` and `phy_wdata` hold steady.
- R12: While `rst` is 1, `link_up`, `phy_req`, `rec_busy`, `rec_event`, `rec_fail` and `rec_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_dbg0 | input | 32 | Training debug word; [5:0] is the state code |
| lt_dbg1 | input | 32 | Training debug word; bit 4 set means still training |
| phy_req | output | 1 | PHY access request, held until acknowledged |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | One-cycle completion of the current access |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |
| phy_err | input | 1 | Access error, valid with `phy_ack` |
| link_up | output | 1 | Link has left training |
| rec_busy | output | 1 | Check or recovery sequence in progress |
| rec_event | output | 1 | One-cycle pulse per completed recovery |
| rec_fail | output | 1 | One-cycle pulse per aborted sequence |
| rec_count | output | 8 | Completed recovery count, wraps |

## Verification
The bench breaks the stall condition one cycle before the dwell expires and then checks the restart distance. A monitor that did not restart its count would probe too early. The bench sets override data with other bits already set or already cleared, which catches a design that writes the mask alone or clears bits it should keep. It measures the hold gap to the exact cycle, so an off-by-one timer shows up. Errors are placed on each of the four accesses in turn. This catches an abort path that leaves the override bits set, writes stale data, or counts a failed sequence as a success.

// File: rtl/g2sr_pkg.sv
package g2sr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CHK  = 3'd1,
    ST_ORD  = 3'd2,
    ST_OWR  = 3'd3,
    ST_HOLD = 3'd4,
    ST_CRD  = 3'd5,
    ST_CWR  = 3'd6
  } g2sr_st_e;

endpackage

// File: rtl/g2sr_decode.sv
module g2sr_decode #(
  parameter int DW = 32,
  parameter int TRAIN_BIT = 4,
  parameter int LTSSM_W = 6,
  parameter logic [LTSSM_W-1:0] STUCK_CODE = 6'h0D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] dbg0,
  input  logic [DW-1:0] dbg1,
  output logic          stuck_now,
  output logic          link_up
);

  logic training;
  logic unused_dbg;

  assign training   = dbg1[TRAIN_BIT];
  assign stuck_now  = !training && (dbg0[LTSSM_W-1:0] == STUCK_CODE);
  assign unused_dbg = ^{dbg0, dbg1};

  always_ff @(posedge clk) begin
    if (rst) link_up <= 1'b0;
    else     link_up <= !training;
  end

endmodule

// File: rtl/g2sr_tick.sv
module g2sr_tick #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic fire
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (en) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        fire <= 1'b1;
      end else begin
        cnt  <= cnt + CW'(1);
        fire <= 1'b0;
      end
    end else begin
      cnt  <= '0;
      fire <= 1'b0;
    end
  end

endmodule

// File: rtl/g2sr_seq.sv
module g2sr_seq
  import g2sr_pkg::*;
#(
  parameter int PA_W = 16,
  parameter int PD_W = 16,
  parameter int CNT_W = 8,
  parameter int HOLD_CYC = 312500,
  parameter int RXVALID_BIT = 0,
  parameter logic [PA_W-1:0] RXSTAT_ADDR = 16'h100D,
  parameter logic [PA_W-1:0] OVRD_ADDR = 16'h1005,
  parameter logic [PD_W-1:0] OVRD_MASK = 16'h0028
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             phy_req,
  output logic             phy_we,
  output logic [PA_W-1:0]  phy_addr,
  output logic [PD_W-1:0]  phy_wdata,
  input  logic             phy_ack,
  input  logic [PD_W-1:0]  phy_rdata,
  input  logic             phy_err,
  output logic             busy,
  output logic             evt,
  output logic             fail,
  output logic [CNT_W-1:0] count
);

  g2sr_st_e       st;
  logic [PD_W-1:0] orig;
  logic            abort;
  logic            hold_en;
  logic            hold_done;

  assign hold_en = (st == ST_HOLD);
  assign busy    = (st != ST_IDLE);

  g2sr_tick #(.LIMIT(HOLD_CYC)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .en   (hold_en),
    .fire (hold_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      phy_req   <= 1'b0;
      phy_we    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
      orig      <= '0;
      abort     <= 1'b0;
      evt       <= 1'b0;
      fail      <= 1'b0;
      count     <= '0;
    end else begin
      evt  <= 1'b0;
      fail <= 1'b0;
      case (st)
        ST_IDLE: begin
          abort <= 1'b0;
          if (start) begin
            st        <= ST_CHK;
            phy_req   <= 1'b1;
            phy_we    <= 1'b0;
            phy_addr  <= RXSTAT_ADDR;
            phy_wdata <= '0;
          end
        end
        ST_CHK: begin
          if (phy_ack) begin
            if (phy_err) begin
              phy_req <= 1'b0;
              fail    <= 1'b1;
              st      <= ST_IDLE;
            end else if (phy_rdata[RXVALID_BIT]) begin
              phy_req <= 1'b0;
              st      <= ST_IDLE;
            end else begin
              phy_addr <= OVRD_ADDR;
              st       <= ST_ORD;
            end
          end
        end
        ST_ORD: begin
          if (phy_ack) begin
            if (phy_err) begin
              phy_req <= 1'b0;
              fail    <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              orig      <= phy_rdata;
              phy_we    <= 1'b1;
              phy_wdata <= phy_rdata | OVRD_MASK;
              st        <= ST_OWR;
            end
          end
        end
        ST_OWR: begin
          if (phy_ack) begin
            if (phy_err) begin
              abort     <= 1'b1;
              phy_wdata <= orig & ~OVRD_MASK;
              st        <= ST_CWR;
            end else begin
              phy_req <= 1'b0;
              phy_we  <= 1'b0;
              st      <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (hold_done) begin
            phy_req  <= 1'b1;
            phy_we   <= 1'b0;
            phy_addr <= OVRD_ADDR;
            st       <= ST_CRD;
          end
        end
        ST_CRD: begin
          if (phy_ack) begin
            phy_we <= 1'b1;
            st     <= ST_CWR;
            if (phy_err) begin
              abort     <= 1'b1;
              phy_wdata <= orig & ~OVRD_MASK;
            end else begin
              phy_wdata <= phy_rdata & ~OVRD_MASK;
            end
          end
        end
        ST_CWR: begin
          if (phy_ack) begin
            phy_req <= 1'b0;
            phy_we  <= 1'b0;
            st      <= ST_IDLE;
            if (phy_err || abort) begin
              fail <= 1'b1;
            end else begin
              evt   <= 1'b1;
              count <= count + CNT_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/g2_stall_rescue.sv
module g2_stall_rescue #(
  parameter int DW = 32,
  parameter int PA_W = 16,
  parameter int PD_W = 16,
  parameter int CNT_W = 8,
  parameter int TRAIN_BIT = 4,
  parameter int LTSSM_W = 6,
  parameter logic [LTSSM_W-1:0] STUCK_CODE = 6'h0D,
  parameter int DWELL_CYC = 250000,
  parameter int HOLD_CYC = 312500,
  parameter int RXVALID_BIT = 0,
  parameter logic [PA_W-1:0] RXSTAT_ADDR = 16'h100D,
  parameter logic [PA_W-1:0] OVRD_ADDR = 16'h1005,
  parameter logic [PD_W-1:0] OVRD_MASK = 16'h0028
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    lt_dbg0,
  input  logic [DW-1:0]    lt_dbg1,
  output logic             phy_req,
  output logic             phy_we,
  output logic [PA_W-1:0]  phy_addr,
  output logic [PD_W-1:0]  phy_wdata,
  input  logic             phy_ack,
  input  logic [PD_W-1:0]  phy_rdata,
  input  logic             phy_err,
  output logic             link_up,
  output logic             rec_busy,
  output logic             rec_event,
  output logic             rec_fail,
  output logic [CNT_W-1:0] rec_count
);

  logic stuck_now;
  logic dwell_en;
  logic dwell_done;

  g2sr_decode #(
    .DW(DW), .TRAIN_BIT(TRAIN_BIT), .LTSSM_W(LTSSM_W), .STUCK_CODE(STUCK_CODE)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .dbg0      (lt_dbg0),
    .dbg1      (lt_dbg1),
    .stuck_now (stuck_now),
    .link_up   (link_up)
  );

  assign dwell_en = stuck_now && !rec_busy;

  g2sr_tick #(.LIMIT(DWELL_CYC)) u_dwell (
    .clk  (clk),
    .rst  (rst),
    .en   (dwell_en),
    .fire (dwell_done)
  );

  g2sr_seq #(
    .PA_W(PA_W), .PD_W(PD_W), .CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC),
    .RXVALID_BIT(RXVALID_BIT), .RXSTAT_ADDR(RXSTAT_ADDR),
    .OVRD_ADDR(OVRD_ADDR), .OVRD_MASK(OVRD_MASK)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (dwell_done),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack),
    .phy_rdata (phy_rdata),
    .phy_err   (phy_err),
    .busy      (rec_busy),
    .evt       (rec_event),
    .fail      (rec_fail),
    .count     (rec_count)
  );

endmodule

// File: rtl/g2sr_chk.sv
module g2sr_chk #(
  parameter int DW = 32,
  parameter int PA_W = 16,
  parameter int PD_W = 16,
  parameter int CNT_W = 8,
  parameter int TRAIN_BIT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [DW-1:0]    lt_dbg1,
  input logic             phy_req,
  input logic             phy_we,
  input logic [PA_W-1:0]  phy_addr,
  input logic [PD_W-1:0]  phy_wdata,
  input logic             phy_ack,
  input logic             link_up,
  input logic             rec_busy,
  input logic             rec_event,
  input logic             rec_fail,
  input logic [CNT_W-1:0] rec_count
);

  p_link_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (link_up == !$past(lt_dbg1[TRAIN_BIT])));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_ack) |=> phy_req);

  p_req_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_ack) |=> ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

  p_req_busy_r8: assert property (@(posedge clk) disable iff (rst)
    phy_req |-> rec_busy);

  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    rec_event |-> (rec_count == $past(rec_count) + CNT_W'(1)));

  p_fail_nocount_r9: assert property (@(posedge clk) disable iff (rst)
    rec_fail |-> $stable(rec_count));

  p_outcome_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rec_event, rec_fail}));

endmodule

bind g2_stall_rescue g2sr_chk #(
  .DW(DW), .PA_W(PA_W), .PD_W(PD_W), .CNT_W(CNT_W), .TRAIN_BIT(TRAIN_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lt_dbg1   (lt_dbg1),
  .phy_req   (phy_req),
  .phy_we    (phy_we),
  .phy_addr  (phy_addr),
  .phy_wdata (phy_wdata),
  .phy_ack   (phy_ack),
  .link_up   (link_up),
  .rec_busy  (rec_busy),
  .rec_event (rec_event),
  .rec_fail  (rec_fail),
  .rec_count (rec_count)
);

// File: tb/sim_g2_stall_rescue.sv
`timescale 1ns/1ps
module sim_g2_stall_rescue;

  localparam int DWELL = 16;
  localparam int HOLD  = 24;
  localparam logic [31:0] LO_STUCK = 32'hABCD_00CD;  // [5:0] = 0x0D
  localparam logic [31:0] LO_IDLE  = 32'h0000_0011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lt_dbg0 = LO_IDLE;
  logic [31:0] lt_dbg1 = 32'h0;
  logic        phy_req, phy_we;
  logic [15:0] phy_addr, phy_wdata;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_rdata = 16'h0;
  logic        phy_err = 1'b0;
  logic        link_up, rec_busy, rec_event, rec_fail;
  logic [7:0]  rec_count;

  always #4 clk = ~clk;  // 125 MHz

  g2_stall_rescue #(.DWELL_CYC(DWELL), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst(rst), .lt_dbg0(lt_dbg0), .lt_dbg1(lt_dbg1),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata), .phy_err(phy_err),
    .link_up(link_up), .rec_busy(rec_busy), .rec_event(rec_event),
    .rec_fail(rec_fail), .rec_count(rec_count)
  );

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        err;
  } item_t;

  item_t exp_q[$];
  int    t_req[$];
  int    t_ack[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    ev_n = 0;
  int    fl_n = 0;
  int    n_acc = 0;
  bit    pend = 0;
  int    lat = 0;
  item_t cur;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [15:0] addr, input logic [15:0] wdata,
                      input logic [15:0] rdata, input logic err);
    item_t it;
    it.we = we; it.addr = addr; it.wdata = wdata; it.rdata = rdata; it.err = err;
    exp_q.push_back(it);
  endtask

  // PHY responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      ev_n += int'(rec_event);
      fl_n += int'(rec_fail);
    end
    if (phy_ack) begin
      phy_ack   = 1'b0;
      phy_rdata = 16'h0;
      phy_err   = 1'b0;
    end
    if (pend) begin
      if (lat == 0) begin
        phy_ack   = 1'b1;
        phy_rdata = cur.rdata;
        phy_err   = cur.err;
        t_ack.push_back(cyc);
        pend = 0;
      end else begin
        lat--;
      end
    end else if (!rst && phy_req) begin
      n_acc++;
      t_req.push_back(cyc);
      if (exp_q.size() == 0) begin
        check("R2/R8 unexpected request addr", {16'h0, phy_addr}, 32'hFFFF_FFFF);
        cur.we = phy_we; cur.addr = phy_addr; cur.wdata = 16'h0; cur.rdata = 16'h0; cur.err = 1'b0;
      end else begin
        cur = exp_q.pop_front();
        check("R5/R6 request kind", {31'h0, phy_we}, {31'h0, cur.we});
        check("R3/R5 request addr", {16'h0, phy_addr}, {16'h0, cur.addr});
        if (cur.we) check("R5/R6/R10 write data", {16'h0, phy_wdata}, {16'h0, cur.wdata});
        check("R8 busy during access", {31'h0, rec_busy}, 32'h1);
      end
      pend = 1;
      lat  = 2;
    end
  end

  task automatic wait_idle(input string tag);
    int k = 0;
    while (!rec_busy && k < 1000) begin @(negedge clk); k++; end
    while (rec_busy && k < 2000) begin @(negedge clk); k++; end
    if (k >= 2000) check({tag, " timeout"}, 32'h1, 32'h0);
  endtask

  task automatic run_case(input string tag, input int exp_ev, input int exp_fl);
    int e0 = ev_n;
    int f0 = fl_n;
    int ts;
    t_req.delete();
    t_ack.delete();
    lt_dbg0 = LO_STUCK;
    ts = cyc;
    wait_idle(tag);
    lt_dbg0 = LO_IDLE;
    repeat (4) @(negedge clk);
    if (t_req.size() > 0) check({tag, " R3 dwell distance"}, t_req[0] - ts, DWELL + 1);
    check({tag, " R8 all expected accesses used"}, exp_q.size(), 0);
    check({tag, " R7 event pulses"}, ev_n - e0, exp_ev);
    check({tag, " R9/R10 fail pulses"}, fl_n - f0, exp_fl);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R12: reset state
    check("R12 link_up in reset", {31'h0, link_up}, 32'h0);
    check("R12 phy_req in reset", {31'h0, phy_req}, 32'h0);
    check("R12 rec_busy in reset", {31'h0, rec_busy}, 32'h0);
    check("R12 pulses in reset", {30'h0, rec_event, rec_fail}, 32'h0);
    check("R12 count in reset", {24'h0, rec_count}, 32'h0);
    rst = 1'b0;

    // R1: link indication follows bit 4 only
    lt_dbg1 = 32'h0000_0010;
    @(negedge clk);
    check("R1 training -> link_up 0", {31'h0, link_up}, 32'h0);
    lt_dbg1 = 32'hFFFF_FFEF;
    @(negedge clk);
    check("R1 other bits set, bit4 clear -> link_up 1", {31'h0, link_up}, 32'h1);
    lt_dbg1 = 32'h0;
    @(negedge clk);

    // R2: stuck code while still training
    lt_dbg1 = 32'h0000_0010;
    lt_dbg0 = LO_STUCK;
    begin
      int a0 = n_acc;
      int seen = 0;
      for (int i = 0; i < 4 * DWELL; i++) begin
        @(negedge clk);
        seen += int'(phy_req);
      end
      check("R2 no request while training", seen, 0);
      check("R2 no access accepted", n_acc - a0, 0);
    end
    lt_dbg0 = LO_IDLE;
    lt_dbg1 = 32'h0;
    repeat (3) @(negedge clk);

    // R3: interrupted dwell restarts; R4: receiver valid -> no action
    push(1'b0, 16'h100D, 16'h0, 16'h0001, 1'b0);
    t_req.delete();
    lt_dbg0 = LO_STUCK;
    repeat (DWELL - 1) @(negedge clk);
    lt_dbg0 = LO_IDLE;
    @(negedge clk);
    check("R3 no request before dwell", {31'h0, phy_req}, 32'h0);
    run_case("R3R4 valid receiver", 0, 0);
    check("R4 single access only", t_req.size(), 1);
    check("R4 count unchanged", {24'h0, rec_count}, 32'h0);

    // R5 R6 R7: full recovery
    push(1'b0, 16'h100D, 16'h0, 16'h0000, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'h1234, 1'b0);
    push(1'b1, 16'h1005, 16'h123C, 16'h0, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'hFFFF, 1'b0);
    push(1'b1, 16'h1005, 16'hFFD7, 16'h0, 1'b0);
    run_case("R5R6R7 full recovery", 1, 0);
    if (t_req.size() == 5 && t_ack.size() >= 3)
      check("R6 hold distance", t_req[3] - t_ack[2], HOLD + 2);
    else check("R6 access sequence length", t_req.size(), 5);
    check("R7 count after first recovery", {24'h0, rec_count}, 32'h1);

    // R9: error on confirmation read
    push(1'b0, 16'h100D, 16'h0, 16'h0000, 1'b1);
    run_case("R9 check-read error", 0, 1);
    // R9: error on first override read
    push(1'b0, 16'h100D, 16'h0, 16'h0000, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'h1234, 1'b1);
    run_case("R9 override-read error", 0, 1);
    check("R9 count unchanged", {24'h0, rec_count}, 32'h1);

    // R10: error on setting write -> immediate clearing write of original
    push(1'b0, 16'h100D, 16'h0, 16'h0000, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'h1234, 1'b0);
    push(1'b1, 16'h1005, 16'h123C, 16'h0, 1'b1);
    push(1'b1, 16'h1005, 16'h1214, 16'h0, 1'b0);
    run_case("R10 set-write error", 0, 1);
    // R10: error on clearing read
    push(1'b0, 16'h100D, 16'h0, 16'h0000, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'h00FF, 1'b0);
    push(1'b1, 16'h1005, 16'h00FF, 16'h0, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'hAAAA, 1'b1);
    push(1'b1, 16'h1005, 16'h00D7, 16'h0, 1'b0);
    run_case("R10 clear-read error", 0, 1);
    check("R10 count unchanged", {24'h0, rec_count}, 32'h1);

    // R5 R7: second recovery with bits initially clear
    push(1'b0, 16'h100D, 16'h0, 16'h0000, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'h0000, 1'b0);
    push(1'b1, 16'h1005, 16'h0028, 16'h0, 1'b0);
    push(1'b0, 16'h1005, 16'h0, 16'h0028, 1'b0);
    push(1'b1, 16'h1005, 16'h0000, 16'h0, 1'b0);
    run_case("R5R7 second recovery", 1, 0);
    check("R7 count after second recovery", {24'h0, rec_count}, 32'h2);
    check("R8 idle at end", {31'h0, rec_busy}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired (R8) actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule